// File: doc/BRIEF.md
# Byte FIFO Pair with Trigger-Level Interrupt Logic

This block sits between a simple register bus and a serial-bus byte engine. It holds one byte queue for each direction. The host pushes outgoing bytes by writing a data register, and the engine drains them one at a time. The engine deposits incoming bytes, and the host pops them by reading a data register. Each queue can be enabled on its own. Each has a programmable trigger level. The host can read each queue's fill level and its full and empty flags in one status word.

Twelve interrupt causes collect in a sticky status register. A software write of ones clears the matching bits. Two causes are level-driven: the outgoing queue is running low, or the incoming queue is filling up. Four causes report a push into a full queue or a pop from an empty one, in each direction. One cause comes from a trailing-byte timer. When the bus has gone idle and a few received bytes sit below the trigger level, this timer flags them so that software collects them instead of waiting for the trigger. Five causes come straight from the engine's transfer-result pulses. An enable register masks the single interrupt line.

The trailing timer is a three-state machine:
- **TRL_IDLE**: the timer waits.
- **TRL_COUNT**: the timer counts down a 4-bit reload value.
- **TRL_HOLD**: the timer has fired and waits for the condition to clear.

The transitions are:
- **arm**: IDLE to COUNT when the condition becomes true.
- **abandon**: COUNT to IDLE when the condition drops.
- **expire**: COUNT to HOLD when the count is zero and the condition still holds.
- **release**: HOLD to IDLE when the condition drops.

Top module: `dual_fifo_irq`

Register word addresses (`reg_addr_i`):
- 0: configuration. Bit 0 enables the RX queue. Bit 1 enables the TX queue. Bits 10:4 hold the RX trigger. Bits 22:16 hold the TX trigger.
- 1: levels/status word.
- 2: interrupt enable, bits 11:0.
- 3: interrupt status, bits 11:0. A write of ones clears.
- 4: TX data. A write pushes bits 7:0.
- 5: RX data. A read shows the head byte, and the read strobe pops it.
- 6: trailing reload value, bits 3:0.

## Requirements
- R1: After reset both queues are empty, the configuration, enable and status registers read 0, the status word reads 0x0100_0100, and `irq_o` is low.
- R2: Bytes leave each queue in the order they entered. `eng_tx_data_o` and the RX data register show the current head byte, or 0 when the queue is empty.
- R3: The status word carries the TX level in bits 6:0, TX full at bit 7 and TX empty at bit 8. It carries the RX level in bits 22:16, RX full at bit 23 and RX empty at bit 24. All other bits are 0.
- R4: A push into a full enabled queue is dropped, and the queue contents are unchanged. It sets cause bit 3 for TX or cause bit 5 for RX.
- R5: A pop from an empty enabled queue yields 0. It sets cause bit 2 for TX or cause bit 4 for RX.
- R6: Cause bit 0 is set at every clock edge at which the TX queue is enabled and its level is at or below the TX trigger. Cause bit 1 is set at every clock edge at which the RX queue is enabled and its level is at or above the RX trigger.
- R7: A disabled queue is flushed to empty. Pushes and pops on it are ignored and raise no cause.
- R8: A pulse on `xfer_evt_i[k]` sets cause bit 7+k. The bits map in this order: done, abort, no-ack, no-device, timeout.
- R9: A write to the status register clears exactly the bits written as 1. A cause raised in the same cycle stays set.
- R10: `irq_o` is high exactly when some status bit and its enable bit are both 1.
- R11: Take the condition where RX is enabled, `bus_idle_i` is high and the RX level is between 1 and trigger−1. If that condition holds at N+2 consecutive clock edges, with N the reload value, cause bit 6 is set at the last of them.
- R12: The trailing cause fires once per episode. After being cleared, it is not raised again until the condition has dropped for at least one edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr_i | input | 1 | Register write strobe |
| reg_rd_i | input | 1 | Register read strobe (pops RX at address 5) |
| reg_addr_i | input | 3 | Register word address |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data, combinational on address |
| eng_tx_pop_i | input | 1 | Engine takes the TX head byte |
| eng_tx_data_o | output | 8 | TX head byte (0 if empty) |
| eng_rx_push_i | input | 1 | Engine delivers a received byte |
| eng_rx_data_i | input | 8 | Received byte |
| bus_idle_i | input | 1 | Serial bus is idle |
| xfer_evt_i | input | 5 | Transfer-result pulses: done, abort, no-ack, no-device, timeout |
| irq_o | output | 1 | Masked interrupt line |

## Verification
Both queues are filled in steps across their trigger levels, so the level-driven causes are seen on both sides of the at-or-below and at-or-above boundaries. Each queue is also filled to depth and pushed once more, then drained past empty. This separates a correct drop-and-flag from wrap or count errors, and the byte order on draining exposes pointer mistakes. Status writes are made with partial masks, and with a cause firing in the same cycle, which distinguishes exact write-one-to-clear from a full clear or clear-wins priority. The trailing timer is run for its exact expiry edge, then held after clearing, then re-armed, which tells an off-by-one count and a re-triggering timer apart from the correct one-shot behaviour.

// File: rtl/dfi_pkg.sv
package dfi_pkg;
    localparam int DATA_W    = 8;
    localparam int LVL_W     = 7;
    localparam int TRIG_W    = 7;
    localparam int NCAUSE    = 12;
    localparam int TRL_LEN_W = 4;

    localparam int CFG_RX_EN       = 0;
    localparam int CFG_TX_EN       = 1;
    localparam int CFG_RX_TRIG_LSB = 4;
    localparam int CFG_TX_TRIG_LSB = 16;
    localparam logic [31:0] CFG_MASK = 32'h007F_07F3;

    localparam int C_TX_LOW   = 0;
    localparam int C_RX_HIGH  = 1;
    localparam int C_TX_UNF   = 2;
    localparam int C_TX_OVF   = 3;
    localparam int C_RX_UNF   = 4;
    localparam int C_RX_OVF   = 5;
    localparam int C_TRAIL    = 6;
    localparam int C_EVT_LSB  = 7;
    localparam int NEVT       = 5;

    typedef enum logic [2:0] {
        REG_CFG  = 3'd0,
        REG_LVL  = 3'd1,
        REG_IEN  = 3'd2,
        REG_STAT = 3'd3,
        REG_TXD  = 3'd4,
        REG_RXD  = 3'd5,
        REG_TRL  = 3'd6
    } reg_sel_e;

    typedef enum logic [1:0] {
        TRL_IDLE  = 2'd0,
        TRL_COUNT = 2'd1,
        TRL_HOLD  = 2'd2
    } trl_state_e;
endpackage

// File: rtl/dfi_byte_fifo.sv
module dfi_byte_fifo #(
    parameter int DEPTH = 16,
    parameter int DW    = 8,
    localparam int AW   = $clog2(DEPTH),
    localparam int CW   = $clog2(DEPTH) + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en_i,
    input  logic          push_i,
    input  logic [DW-1:0] push_data_i,
    input  logic          pop_i,
    output logic [DW-1:0] head_o,
    output logic [CW-1:0] level_o,
    output logic          full_o,
    output logic          empty_o,
    output logic          ovf_o,
    output logic          unf_o
);
    logic [DW-1:0] mem [DEPTH];
    logic [AW-1:0] rptr_q, wptr_q;
    logic [CW-1:0] cnt_q;
    logic          do_push, do_pop;

    assign full_o  = (cnt_q == CW'(DEPTH));
    assign empty_o = (cnt_q == '0);
    assign do_push = en_i & push_i & ~full_o;
    assign do_pop  = en_i & pop_i & ~empty_o;
    assign ovf_o   = en_i & push_i & full_o;
    assign unf_o   = en_i & pop_i & empty_o;
    assign level_o = cnt_q;
    assign head_o  = empty_o ? '0 : mem[rptr_q];

    function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
    endfunction

    always_ff @(posedge clk) begin
        if (!rst_n || !en_i) begin
            rptr_q <= '0;
            wptr_q <= '0;
            cnt_q  <= '0;
        end else begin
            if (do_push) wptr_q <= bump(wptr_q);
            if (do_pop)  rptr_q <= bump(rptr_q);
            cnt_q <= cnt_q + CW'(do_push) - CW'(do_pop);
        end
    end

    always_ff @(posedge clk) begin
        if (do_push) mem[wptr_q] <= push_data_i;
    end
endmodule

// File: rtl/dfi_trail_timer.sv
module dfi_trail_timer
    import dfi_pkg::*;
#(
    parameter int LW = TRL_LEN_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cond_i,
    input  logic [LW-1:0] len_i,
    output logic          fire_o
);
    trl_state_e    state_q, state_d;
    logic [LW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= TRL_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            TRL_IDLE:  if (cond_i) state_d = TRL_COUNT;
            TRL_COUNT: begin
                if (!cond_i)          state_d = TRL_IDLE;
                else if (cnt_q == '0) state_d = TRL_HOLD;
            end
            TRL_HOLD:  if (!cond_i) state_d = TRL_IDLE;
            default:   state_d = TRL_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (state_q == TRL_IDLE && cond_i) begin
            cnt_q <= len_i;
        end else if (state_q == TRL_COUNT && cond_i && cnt_q != '0) begin
            cnt_q <= cnt_q - LW'(1);
        end
    end

    always_comb begin
        fire_o = (state_q == TRL_COUNT) && cond_i && (cnt_q == '0);
    end
endmodule

// File: rtl/dfi_irq_ctrl.sv
module dfi_irq_ctrl #(
    parameter int N = 12
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set_i,
    input  logic [N-1:0] clr_i,
    input  logic         en_wr_i,
    input  logic [N-1:0] en_data_i,
    output logic [N-1:0] stat_o,
    output logic [N-1:0] en_o,
    output logic         irq_o
);
    logic [N-1:0] stat_q, en_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stat_q <= '0;
            en_q   <= '0;
        end else begin
            stat_q <= (stat_q & ~clr_i) | set_i;
            if (en_wr_i) en_q <= en_data_i;
        end
    end

    assign stat_o = stat_q;
    assign en_o   = en_q;
    assign irq_o  = |(stat_q & en_q);
endmodule

// File: rtl/dual_fifo_irq.sv
module dual_fifo_irq
    import dfi_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int CW   = $clog2(DEPTH) + 1
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_wr_i,
    input  logic        reg_rd_i,
    input  logic [2:0]  reg_addr_i,
    input  logic [31:0] reg_wdata_i,
    output logic [31:0] reg_rdata_o,
    input  logic        eng_tx_pop_i,
    output logic [7:0]  eng_tx_data_o,
    input  logic        eng_rx_push_i,
    input  logic [7:0]  eng_rx_data_i,
    input  logic        bus_idle_i,
    input  logic [4:0]  xfer_evt_i,
    output logic        irq_o
);
    logic [31:0]          cfg_q;
    logic [TRL_LEN_W-1:0] trl_len_q;
    logic                 tx_en, rx_en;
    logic [TRIG_W-1:0]    tx_trig, rx_trig;

    logic [CW-1:0]     tx_level, rx_level;
    logic [LVL_W-1:0]  tx_lvl7, rx_lvl7;
    logic              tx_full, tx_empty, rx_full, rx_empty;
    logic              tx_ovf, tx_unf, rx_ovf, rx_unf;
    logic [7:0]        rx_head;
    logic              host_push, host_pop, stat_wr;
    logic              trail_cond, trail_fire;
    logic [NCAUSE-1:0] cause_set, cause_clr, irq_stat, irq_en;

    assign tx_en   = cfg_q[CFG_TX_EN];
    assign rx_en   = cfg_q[CFG_RX_EN];
    assign tx_trig = cfg_q[CFG_TX_TRIG_LSB +: TRIG_W];
    assign rx_trig = cfg_q[CFG_RX_TRIG_LSB +: TRIG_W];

    assign host_push = reg_wr_i && (reg_addr_i == REG_TXD);
    assign host_pop  = reg_rd_i && (reg_addr_i == REG_RXD);
    assign stat_wr   = reg_wr_i && (reg_addr_i == REG_STAT);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q     <= '0;
            trl_len_q <= '0;
        end else if (reg_wr_i) begin
            if (reg_addr_i == REG_CFG) cfg_q     <= reg_wdata_i & CFG_MASK;
            if (reg_addr_i == REG_TRL) trl_len_q <= reg_wdata_i[TRL_LEN_W-1:0];
        end
    end

    dfi_byte_fifo #(.DEPTH(DEPTH), .DW(DATA_W)) u_tx_fifo (
        .clk         (clk),
        .rst_n       (rst_n),
        .en_i        (tx_en),
        .push_i      (host_push),
        .push_data_i (reg_wdata_i[7:0]),
        .pop_i       (eng_tx_pop_i),
        .head_o      (eng_tx_data_o),
        .level_o     (tx_level),
        .full_o      (tx_full),
        .empty_o     (tx_empty),
        .ovf_o       (tx_ovf),
        .unf_o       (tx_unf)
    );

    dfi_byte_fifo #(.DEPTH(DEPTH), .DW(DATA_W)) u_rx_fifo (
        .clk         (clk),
        .rst_n       (rst_n),
        .en_i        (rx_en),
        .push_i      (eng_rx_push_i),
        .push_data_i (eng_rx_data_i),
        .pop_i       (host_pop),
        .head_o      (rx_head),
        .level_o     (rx_level),
        .full_o      (rx_full),
        .empty_o     (rx_empty),
        .ovf_o       (rx_ovf),
        .unf_o       (rx_unf)
    );

    assign tx_lvl7 = LVL_W'(tx_level);
    assign rx_lvl7 = LVL_W'(rx_level);

    assign trail_cond = rx_en && bus_idle_i && (rx_lvl7 != '0) && (rx_lvl7 < rx_trig);

    dfi_trail_timer #(.LW(TRL_LEN_W)) u_trail (
        .clk    (clk),
        .rst_n  (rst_n),
        .cond_i (trail_cond),
        .len_i  (trl_len_q),
        .fire_o (trail_fire)
    );

    always_comb begin
        cause_set            = '0;
        cause_set[C_TX_LOW]  = tx_en && (tx_lvl7 <= tx_trig);
        cause_set[C_RX_HIGH] = rx_en && (rx_lvl7 >= rx_trig);
        cause_set[C_TX_UNF]  = tx_unf;
        cause_set[C_TX_OVF]  = tx_ovf;
        cause_set[C_RX_UNF]  = rx_unf;
        cause_set[C_RX_OVF]  = rx_ovf;
        cause_set[C_TRAIL]   = trail_fire;
        cause_set[C_EVT_LSB +: NEVT] = xfer_evt_i;
        cause_clr = stat_wr ? reg_wdata_i[NCAUSE-1:0] : '0;
    end

    dfi_irq_ctrl #(.N(NCAUSE)) u_irq (
        .clk       (clk),
        .rst_n     (rst_n),
        .set_i     (cause_set),
        .clr_i     (cause_clr),
        .en_wr_i   (reg_wr_i && (reg_addr_i == REG_IEN)),
        .en_data_i (reg_wdata_i[NCAUSE-1:0]),
        .stat_o    (irq_stat),
        .en_o      (irq_en),
        .irq_o     (irq_o)
    );

    always_comb begin
        case (reg_addr_i)
            REG_CFG:  reg_rdata_o = cfg_q;
            REG_LVL:  reg_rdata_o = {7'b0, rx_empty, rx_full, rx_lvl7,
                                     7'b0, tx_empty, tx_full, tx_lvl7};
            REG_IEN:  reg_rdata_o = {{(32-NCAUSE){1'b0}}, irq_en};
            REG_STAT: reg_rdata_o = {{(32-NCAUSE){1'b0}}, irq_stat};
            REG_RXD:  reg_rdata_o = {24'b0, rx_head};
            REG_TRL:  reg_rdata_o = {{(32-TRL_LEN_W){1'b0}}, trl_len_q};
            default:  reg_rdata_o = '0;
        endcase
    end
endmodule

// File: rtl/dual_fifo_irq_chk.sv
module dual_fifo_irq_chk
    import dfi_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int CW   = $clog2(DEPTH) + 1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              reg_wr_i,
    input logic [2:0]        reg_addr_i,
    input logic [31:0]       reg_wdata_i,
    input logic              eng_tx_pop_i,
    input logic              bus_idle_i,
    input logic [4:0]        xfer_evt_i,
    input logic              tx_en,
    input logic              tx_full,
    input logic              tx_empty,
    input logic [CW-1:0]     tx_level,
    input logic [NCAUSE-1:0] irq_stat
);
    assert_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
        tx_level <= CW'(DEPTH));

    assert_overrun_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr_i && reg_addr_i == REG_TXD && tx_en && tx_full) |=> irq_stat[C_TX_OVF]);

    assert_underrun_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_tx_pop_i && tx_en && tx_empty) |=> irq_stat[C_TX_UNF]);

    assert_flush_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_en |=> (tx_level == '0));

    assert_event_R8: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_evt_i[0] |=> irq_stat[C_EVT_LSB]);

    assert_w1c_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr_i && reg_addr_i == REG_STAT && reg_wdata_i[11] && !xfer_evt_i[4])
        |=> !irq_stat[11]);

    assert_trail_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_stat[C_TRAIL]) |-> $past(bus_idle_i));
endmodule

bind dual_fifo_irq dual_fifo_irq_chk #(.DEPTH(DEPTH)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .reg_wr_i     (reg_wr_i),
    .reg_addr_i   (reg_addr_i),
    .reg_wdata_i  (reg_wdata_i),
    .eng_tx_pop_i (eng_tx_pop_i),
    .bus_idle_i   (bus_idle_i),
    .xfer_evt_i   (xfer_evt_i),
    .tx_en        (tx_en),
    .tx_full      (tx_full),
    .tx_empty     (tx_empty),
    .tx_level     (tx_level),
    .irq_stat     (irq_stat)
);

// File: tb/dual_fifo_irq_tb.sv
module dual_fifo_irq_tb;
    localparam int DEPTH = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0, reg_rd = 1'b0;
    logic [2:0]  reg_addr = 3'd0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        tx_pop = 1'b0;
    logic [7:0]  tx_data;
    logic        rx_push = 1'b0;
    logic [7:0]  rx_data = '0;
    logic        bus_idle = 1'b0;
    logic [4:0]  evt = '0;
    logic        irq;

    always #5 clk = ~clk;

    dual_fifo_irq #(.DEPTH(DEPTH)) u_dut (
        .clk (clk), .rst_n (rst_n),
        .reg_wr_i (reg_wr), .reg_rd_i (reg_rd), .reg_addr_i (reg_addr),
        .reg_wdata_i (reg_wdata), .reg_rdata_o (reg_rdata),
        .eng_tx_pop_i (tx_pop), .eng_tx_data_o (tx_data),
        .eng_rx_push_i (rx_push), .eng_rx_data_i (rx_data),
        .bus_idle_i (bus_idle), .xfer_evt_i (evt), .irq_o (irq)
    );

    int n_cmp = 0, n_bad = 0;
    bit finished = 1'b0;
    string cur = "R1";

    // behavioural reference
    logic [7:0]  txq[$], rxq[$];
    logic [31:0] m_cfg;
    logic [11:0] m_ien, m_stat;
    logic [3:0]  m_tlen;
    int          m_trs, m_trc;

    task automatic m_reset();
        txq.delete(); rxq.delete();
        m_cfg = '0; m_ien = '0; m_stat = '0; m_tlen = '0; m_trs = 0; m_trc = 0;
    endtask

    function automatic logic [31:0] m_rdata(input logic [2:0] a);
        int ts = txq.size(), rs = rxq.size();
        logic [31:0] w = '0;
        case (a)
            3'd0: w = m_cfg;
            3'd1: begin
                w[6:0] = 7'(ts); w[7] = (ts == DEPTH); w[8] = (ts == 0);
                w[22:16] = 7'(rs); w[23] = (rs == DEPTH); w[24] = (rs == 0);
            end
            3'd2: w = {20'b0, m_ien};
            3'd3: w = {20'b0, m_stat};
            3'd5: w = (rs > 0) ? {24'b0, rxq[0]} : '0;
            3'd6: w = {28'b0, m_tlen};
            default: w = '0;
        endcase
        return w;
    endfunction

    task automatic m_step();
        int ts = txq.size(), rs = rxq.size();
        bit txen = m_cfg[1], rxen = m_cfg[0];
        int rxt = int'(m_cfg[10:4]), txt = int'(m_cfg[22:16]);
        logic [11:0] set = '0, clr = '0;
        bit cond, fire = 0;
        if (txen && ts <= txt) set[0] = 1;
        if (rxen && rs >= rxt) set[1] = 1;
        cond = rxen && bus_idle && rs > 0 && rs < rxt;
        case (m_trs)
            0: if (cond) begin m_trs = 1; m_trc = int'(m_tlen); end
            1: if (!cond) m_trs = 0;
               else if (m_trc == 0) begin fire = 1; m_trs = 2; end
               else m_trc--;
            default: if (!cond) m_trs = 0;
        endcase
        set[6] = fire;
        if (txen) begin
            if (tx_pop) begin if (ts == 0) set[2] = 1; else void'(txq.pop_front()); end
            if (reg_wr && reg_addr == 3'd4) begin
                if (ts == DEPTH) set[3] = 1; else txq.push_back(reg_wdata[7:0]);
            end
        end else txq.delete();
        if (rxen) begin
            if (reg_rd && reg_addr == 3'd5) begin if (rs == 0) set[4] = 1; else void'(rxq.pop_front()); end
            if (rx_push) begin if (rs == DEPTH) set[5] = 1; else rxq.push_back(rx_data); end
        end else rxq.delete();
        set[11:7] = evt;
        if (reg_wr && reg_addr == 3'd3) clr = reg_wdata[11:0];
        m_stat = (m_stat & ~clr) | set;
        if (reg_wr) case (reg_addr)
            3'd0: m_cfg = reg_wdata & 32'h007F07F3;
            3'd2: m_ien = reg_wdata[11:0];
            3'd6: m_tlen = reg_wdata[3:0];
            default: ;
        endcase
    endtask

    task automatic check(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic compare_all();
        check(cur, "irq_o", {31'b0, irq}, {31'b0, |(m_stat & m_ien)});
        check(cur, "eng_tx_data_o", {24'b0, tx_data}, (txq.size() > 0) ? {24'b0, txq[0]} : '0);
        check(cur, "reg_rdata_o", reg_rdata, m_rdata(reg_addr));
    endtask

    task automatic tick();
        m_step();
        @(negedge clk);
        compare_all();
        reg_wr = 0; reg_rd = 0; tx_pop = 0; rx_push = 0; evt = '0;
    endtask

    task automatic host_wr(input logic [2:0] a, input logic [31:0] d);
        reg_wr = 1; reg_addr = a; reg_wdata = d; tick();
    endtask

    task automatic host_rd(input logic [2:0] a);
        reg_rd = 1; reg_addr = a; tick();
    endtask

    task automatic peek(input logic [2:0] a, output logic [31:0] v);
        reg_addr = a; #1; v = reg_rdata;
    endtask

    initial begin
        logic [31:0] v;
        m_reset();
        repeat (3) @(negedge clk);
        rst_n = 1;

        // R1 reset state
        cur = "R1";
        peek(3'd1, v); check("R1", "levels", v, 32'h0100_0100);
        peek(3'd3, v); check("R1", "status", v, 0);
        peek(3'd0, v); check("R1", "config", v, 0);
        check("R1", "irq", {31'b0, irq}, 0);
        tick();

        // R6 enable both, rx trig 4, tx trig 2
        cur = "R6";
        host_wr(3'd0, 32'h0002_0043);
        tick();
        peek(3'd3, v); check("R6", "tx low set / rx high clear", v & 32'h3, 32'h1);

        // R2/R3 TX order and layout
        cur = "R2";
        host_wr(3'd4, 32'hA1); host_wr(3'd4, 32'hB2); host_wr(3'd4, 32'hC3);
        peek(3'd1, v); check("R3", "levels after 3 tx", v, 32'h0100_0003);
        check("R2", "tx head", {24'b0, tx_data}, 32'hA1);
        cur = "R6";
        host_wr(3'd3, 32'h1);
        peek(3'd3, v); check("R6", "tx low clear above trigger", v & 32'h1, 0);
        cur = "R2";
        tx_pop = 1; tick();
        check("R2", "tx head 2", {24'b0, tx_data}, 32'hB2);
        tick();
        peek(3'd3, v); check("R6", "tx low at trigger", v & 32'h1, 32'h1);
        tx_pop = 1; tick();
        check("R2", "tx head 3", {24'b0, tx_data}, 32'hC3);
        tx_pop = 1; tick();
        check("R2", "tx empty data", {24'b0, tx_data}, 0);

        // R4 TX overrun
        cur = "R4";
        for (int i = 0; i < DEPTH; i++) host_wr(3'd4, 32'h10 + i);
        peek(3'd1, v); check("R3", "tx full levels", v, 32'h0100_0090);
        host_wr(3'd3, 32'hFFF);
        host_wr(3'd4, 32'hEE);
        peek(3'd3, v); check("R4", "tx overrun cause", v & 32'h8, 32'h8);
        peek(3'd1, v); check("R4", "level unchanged", v, 32'h0100_0090);
        for (int i = 0; i < DEPTH; i++) begin
            check("R4", "drain order", {24'b0, tx_data}, 32'h10 + i);
            tx_pop = 1; tick();
        end

        // R5 TX underrun
        cur = "R5";
        check("R5", "empty data zero", {24'b0, tx_data}, 0);
        host_wr(3'd3, 32'hFFF);
        tx_pop = 1; tick();
        peek(3'd3, v); check("R5", "tx underrun cause", v & 32'h4, 32'h4);

        // R6/R2 RX side
        cur = "R6";
        for (int i = 0; i < 3; i++) begin rx_push = 1; rx_data = 8'h5A + 8'(i * 17); tick(); end
        tick();
        peek(3'd3, v); check("R6", "rx high clear below trigger", v & 32'h2, 0);
        rx_push = 1; rx_data = 8'h8D; tick();
        tick();
        peek(3'd3, v); check("R6", "rx high at trigger", v & 32'h2, 32'h2);
        cur = "R2";
        for (int i = 0; i < 4; i++) begin
            peek(3'd5, v);
            check("R2", "rx order", v, (i < 3) ? 32'h5A + i * 17 : 32'h8D);
            host_rd(3'd5);
        end
        cur = "R5";
        peek(3'd5, v); check("R5", "rx empty reads zero", v, 0);
        host_rd(3'd5);
        peek(3'd3, v); check("R5", "rx underrun cause", v & 32'h10, 32'h10);
        cur = "R4";
        for (int i = 0; i <= DEPTH; i++) begin rx_push = 1; rx_data = 8'(i); tick(); end
        peek(3'd3, v); check("R4", "rx overrun cause", v & 32'h20, 32'h20);
        peek(3'd1, v); check("R3", "rx full levels", v, 32'h0090_0100);

        // R9 write-one-to-clear
        cur = "R9";
        tx_pop = 1; tick();
        host_wr(3'd3, 32'h20);
        peek(3'd3, v); check("R9", "partial clear", v & 32'h34, 32'h14);
        reg_wr = 1; reg_addr = 3'd3; reg_wdata = 32'h4; tx_pop = 1; tick();
        peek(3'd3, v); check("R9", "set wins over clear", v & 32'h4, 32'h4);

        // R8 transfer events
        cur = "R8";
        host_wr(3'd3, 32'hFFF);
        evt = 5'b10101; tick();
        peek(3'd3, v); check("R8", "event causes", v & 32'hF80, 32'hA80);

        // R10 interrupt masking
        cur = "R10";
        check("R10", "masked irq", {31'b0, irq}, 0);
        host_wr(3'd2, 32'h200);
        check("R10", "enabled irq", {31'b0, irq}, 1);
        host_wr(3'd3, 32'h200);
        check("R10", "irq after clear", {31'b0, irq}, 0);
        host_wr(3'd2, 32'h1);
        tick();
        check("R10", "live tx-low irq", {31'b0, irq}, 1);
        host_wr(3'd2, 32'h0);

        // R7 disable TX
        cur = "R7";
        host_wr(3'd4, 32'h77);
        host_wr(3'd0, 32'h0000_0041);
        host_wr(3'd3, 32'hFFF);
        host_wr(3'd4, 32'h33);
        tx_pop = 1; tick();
        tick();
        peek(3'd3, v); check("R7", "no tx causes", v & 32'hD, 0);
        peek(3'd1, v); check("R7", "tx flushed", v & 32'h1FF, 32'h100);
        check("R7", "tx data zero", {24'b0, tx_data}, 0);

        // R11/R12 trailing timer
        cur = "R11";
        host_wr(3'd0, 32'h0);
        host_wr(3'd6, 32'h3);
        host_wr(3'd0, 32'h0000_0041);
        rx_push = 1; rx_data = 8'hC1; tick();
        rx_push = 1; rx_data = 8'hC2; tick();
        host_wr(3'd3, 32'hFFF);
        bus_idle = 1;
        repeat (4) tick();
        peek(3'd3, v); check("R11", "not yet fired", v & 32'h40, 0);
        tick();
        peek(3'd3, v); check("R11", "fired at N+2 edges", v & 32'h40, 32'h40);
        cur = "R12";
        host_wr(3'd3, 32'h40);
        repeat (8) tick();
        peek(3'd3, v); check("R12", "no refire while held", v & 32'h40, 0);
        bus_idle = 0; tick();
        bus_idle = 1;
        repeat (5) tick();
        peek(3'd3, v); check("R11", "refire after new episode", v & 32'h40, 32'h40);

        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog run did not complete: actual=timeout expected=finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule